// File: doc/BRIEF.md
# Page-mode DRAM Controller with CAS-before-RAS Refresh

This block drives an asynchronous dynamic RAM whose row and column addresses share one set of pins. A flat request address is split into a row part (the upper bits) and a column part (the lower bits). The row goes out first and is latched when the active-low row strobe falls. The column follows and is latched when the active-low column strobe falls. An active-low write enable selects the transfer direction. Every phase lasts a parameterised number of clock cycles: row setup, row-to-column delay, column pulse width, column precharge and row precharge.

While the requester keeps presenting words that fall in the open row, the row strobe stays low and only the column strobe pulses, which gives a page-mode burst. The page closes, and the row precharges, when the next request targets another row, when requests stop, or when a refresh is due. A free-running timer requests one refresh every `CLK_KHZ*RETAIN_MS/2**ROW_W` cycles, so that every row is visited once per retention interval. Each refresh lowers the column strobe before the row strobe. In that order the device's own counter picks the row, so the controller holds the address pins at zero.

The requester holds `req_valid`, `req_we`, `req_addr` and `req_wdata` until `done` pulses for that word. It may then present the next word in the same cycle.

Top module: `dram_ctl`

## Requirements
- R1: While reset is asserted and after reset with no request, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are 1, `dram_dq_oe` and `done` are 0, and `dram_addr` is 0.
- R2: At each normal row-strobe fall, `dram_addr` carries `req_addr[ADDR_W-1:COL_W]` (the row). At each later column-strobe fall, it carries `req_addr[COL_W-1:0]` (the column), so the row is always issued before the column.
- R3: In a normal access, the first column-strobe fall comes exactly `T_RCD` cycles after the row-strobe fall, and the column strobe stays low for exactly `T_CAS` cycles.
- R4: For a write (`req_we`=1), `dram_we_n` is 0 and `dram_dq_oe` is 1, with `dram_dq_out` = `req_wdata`, while the column strobe is low. For a read, `dram_we_n` stays 1 and `dram_dq_oe` stays 0.
- R5: For each word, `done` is high for exactly one cycle. For a read, `rd_data` in that cycle holds the device data sampled in the last cycle of the column pulse.
- R6: If the next valid request addresses the open row, the row strobe stays low. The column strobe is high for exactly `T_CP` cycles between pulses, and the row is opened only once for the burst.
- R7: On a row change or when no request is present, the row strobe rises with the column strobe already high and stays high for at least `T_RP` cycles.
- R8: With no traffic, refresh cycles start exactly every `CLK_KHZ*RETAIN_MS/2**ROW_W` cycles. In each one, the column strobe falls first, the row strobe falls `T_CSR` cycles later, and the column strobe stays low for `T_CSR+T_CAS` cycles in total.
- R9: During a refresh cycle, `dram_addr` is 0, `dram_we_n` is 1 and `dram_dq_oe` is 0.
- R10: A due refresh is served before a waiting request and ends an open page burst. The burst then resumes by reopening its row, with no loss of data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; held until `done` |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Flat word address, row in upper bits |
| req_wdata | input | DATA_W | Write data |
| done | output | 1 | One-cycle completion pulse per word |
| rd_data | output | DATA_W | Read data, valid with `done` on reads |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | DATA_W | Data driven to the device |
| dram_dq_oe | output | 1 | Data driver enable |
| dram_dq_in | input | DATA_W | Data returned by the device |

## Verification
Two events can land on the same clock edge: the refresh timer expiring, and the page-continue decision at the end of a column gap. When both occur, the refresh must win and close the page.

The bench provokes this with a read burst of 48 words in one row, which spans several refresh periods. It counts how often the row is reopened, as seen on the pins, against how many refreshes broke into the open burst; the two counts must match plus one. Every word read back must equal the value written earlier, and the pin monitor checks strobe order and phase lengths on each refresh cycle that breaks in.

// File: rtl/dram_ctl_pkg.sv
`timescale 1ns/1ps
package dram_ctl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ROWSET,
      ST_RCD,
      ST_COL,
      ST_PGAP,
      ST_PRE,
      ST_RCAS,
      ST_RRAS
   } dstate_e;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/dram_ref_timer.sv
`timescale 1ns/1ps
module dram_ref_timer #(
   parameter int unsigned PERIOD = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ack,
   output logic pend
);
   localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
   localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

   logic [CW-1:0] cnt;
   logic          expire;

   assign expire = (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         pend <= 1'b0;
      end else begin
         cnt <= expire ? '0 : cnt + 1'b1;
         if (expire)   pend <= 1'b1;
         else if (ack) pend <= 1'b0;
      end
   end

   // the sequencer may only take a refresh that the timer has raised
   assert_ack_only_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> pend);

   // a raised request is not lost before it is taken
   assert_pend_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !ack) |=> pend);

endmodule

// File: rtl/dram_addr_mux.sv
`timescale 1ns/1ps
module dram_addr_mux #(
   parameter int ROW_W = 4,
   parameter int COL_W = 4,
   parameter int MUX_W = 4
) (
   input  logic [ROW_W-1:0] row,
   input  logic [COL_W-1:0] col,
   input  logic             sel_row,
   input  logic             zero,
   output logic [MUX_W-1:0] pins
);
   logic [MUX_W-1:0] row_x;
   logic [MUX_W-1:0] col_x;

   generate
      if (ROW_W == COL_W) begin : g_same
         assign row_x = row;
         assign col_x = col;
      end else if (ROW_W > COL_W) begin : g_row_wide
         assign row_x = row;
         assign col_x = {{(MUX_W-COL_W){1'b0}}, col};
      end else begin : g_col_wide
         assign row_x = {{(MUX_W-ROW_W){1'b0}}, row};
         assign col_x = col;
      end
   endgenerate

   assign pins = zero ? '0 : (sel_row ? row_x : col_x);

endmodule

// File: rtl/dram_seq.sv
`timescale 1ns/1ps
module dram_seq
   import dram_ctl_pkg::*;
#(
   parameter int ROW_W  = 4,
   parameter int DATA_W = 8,
   parameter int T_ASR  = 1,
   parameter int T_RCD  = 2,
   parameter int T_CAS  = 2,
   parameter int T_CP   = 2,
   parameter int T_RP   = 3,
   parameter int T_CSR  = 2,
   parameter int CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_we,
   input  logic [ROW_W-1:0]  req_row,
   input  logic              ref_pend,
   output logic              ref_ack,
   output logic [ROW_W-1:0]  open_row,
   output logic              sel_row,
   output logic              addr_zero,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic              dq_oe,
   input  logic [DATA_W-1:0] dq_in,
   output logic              done,
   output logic [DATA_W-1:0] rd_data
);
   localparam logic [CNT_W-1:0] E_ASR = CNT_W'(T_ASR - 1);
   localparam logic [CNT_W-1:0] E_RCD = CNT_W'(T_RCD - 1);
   localparam logic [CNT_W-1:0] E_CAS = CNT_W'(T_CAS - 1);
   localparam logic [CNT_W-1:0] E_CP  = CNT_W'(T_CP  - 1);
   localparam logic [CNT_W-1:0] E_RP  = CNT_W'(T_RP  - 1);
   localparam logic [CNT_W-1:0] E_CSR = CNT_W'(T_CSR - 1);

   dstate_e          state, nxt;
   logic [CNT_W-1:0] cnt;
   logic             keep_page;

   assign keep_page = req_valid && !ref_pend && (req_row == open_row);

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE:   if (ref_pend)        nxt = ST_RCAS;
                    else if (req_valid)  nxt = ST_ROWSET;
         ST_ROWSET: if (cnt == E_ASR)    nxt = ST_RCD;
         ST_RCD:    if (cnt == E_RCD)    nxt = ST_COL;
         ST_COL:    if (cnt == E_CAS)    nxt = ST_PGAP;
         ST_PGAP:   if (cnt == E_CP)     nxt = keep_page ? ST_COL : ST_PRE;
         ST_PRE:    if (cnt == E_RP)     nxt = ST_IDLE;
         ST_RCAS:   if (cnt == E_CSR)    nxt = ST_RRAS;
         ST_RRAS:   if (cnt == E_CAS)    nxt = ST_PRE;
         default:                        nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         open_row <= '0;
         done     <= 1'b0;
         rd_data  <= '0;
      end else begin
         state <= nxt;
         cnt   <= (nxt != state || state == ST_IDLE) ? '0 : cnt + 1'b1;
         if (state == ST_IDLE && nxt == ST_ROWSET)
            open_row <= req_row;
         if (state == ST_COL && cnt == E_CAS) begin
            done <= 1'b1;
            if (!req_we) rd_data <= dq_in;
         end else begin
            done <= 1'b0;
         end
      end
   end

   assign ref_ack   = (state == ST_IDLE) && ref_pend;
   assign ras_n     = !(state inside {ST_RCD, ST_COL, ST_PGAP, ST_RRAS});
   assign cas_n     = !(state inside {ST_COL, ST_RCAS, ST_RRAS});
   assign we_n      = !((state == ST_COL) && req_we);
   assign dq_oe     = (state == ST_COL) && req_we;
   assign sel_row   = (state == ST_ROWSET) || ((state == ST_RCD) && (cnt == '0));
   assign addr_zero = state inside {ST_IDLE, ST_PRE, ST_RCAS, ST_RRAS};

   // normal access: the row strobe is already low when the column strobe falls
   assert_row_before_col_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cas_n) && !ras_n) |-> $past(!ras_n));

   // refresh: the column strobe was already low when the row strobe falls
   assert_cbr_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ras_n) && !cas_n) |-> $past(!cas_n));

   assert_write_in_open_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> (!ras_n && !cas_n && dq_oe));

   assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_precharge_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_n) |-> (cas_n ##1 ras_n));

   assert_refresh_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && ref_pend) |=> (state == ST_RCAS));

endmodule

// File: rtl/dram_ctl.sv
`timescale 1ns/1ps
module dram_ctl
   import dram_ctl_pkg::*;
#(
   parameter int ROW_W     = 10,
   parameter int COL_W     = 10,
   parameter int DATA_W    = 16,
   parameter int CLK_KHZ   = 200000,
   parameter int RETAIN_MS = 64,
   parameter int T_ASR     = 1,
   parameter int T_RCD     = 3,
   parameter int T_CAS     = 3,
   parameter int T_CP      = 2,
   parameter int T_RP      = 4,
   parameter int T_CSR     = 2,
   localparam int ADDR_W   = ROW_W + COL_W,
   localparam int MUX_W    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_we,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              done,
   output logic [DATA_W-1:0] rd_data,
   output logic [MUX_W-1:0]  dram_addr,
   output logic              dram_ras_n,
   output logic              dram_cas_n,
   output logic              dram_we_n,
   output logic [DATA_W-1:0] dram_dq_out,
   output logic              dram_dq_oe,
   input  logic [DATA_W-1:0] dram_dq_in
);
   localparam int ROWS       = 2 ** ROW_W;
   localparam int REF_CYCLES = (CLK_KHZ * RETAIN_MS) / ROWS;
   localparam int TMAX       = imax(imax(imax(T_ASR, T_RCD), imax(T_CAS, T_CP)),
                                    imax(T_RP, T_CSR));
   localparam int CNT_W      = $clog2(TMAX + 1);
   localparam int REF_MIN    = 2 * (T_ASR + T_RCD + T_CAS + T_CP + T_RP + T_CSR);

   generate
      if (T_ASR < 1 || T_CAS < 1 || T_CSR < 1) begin : g_bad_short
         $error("setup, pulse and refresh lead phases need at least one cycle");
      end
      if (T_RCD < 2) begin : g_bad_rcd
         $error("row-to-column delay must be at least two cycles");
      end
      if (T_CP < 2) begin : g_bad_cp
         $error("column gap must be at least two cycles");
      end
      if (T_RP < 2) begin : g_bad_rp
         $error("row precharge must be at least two cycles");
      end
      if (REF_CYCLES < REF_MIN) begin : g_bad_ref
         $error("refresh period too short for one access plus one refresh");
      end
   endgenerate

   logic             ref_pend, ref_ack, sel_row, addr_zero;
   logic [ROW_W-1:0] open_row;

   dram_ref_timer #(.PERIOD(REF_CYCLES)) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .ack  (ref_ack),
      .pend (ref_pend)
   );

   dram_seq #(
      .ROW_W (ROW_W),  .DATA_W(DATA_W),
      .T_ASR (T_ASR),  .T_RCD (T_RCD), .T_CAS(T_CAS),
      .T_CP  (T_CP),   .T_RP  (T_RP),  .T_CSR(T_CSR),
      .CNT_W (CNT_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_valid(req_valid),
      .req_we   (req_we),
      .req_row  (req_addr[ADDR_W-1:COL_W]),
      .ref_pend (ref_pend),
      .ref_ack  (ref_ack),
      .open_row (open_row),
      .sel_row  (sel_row),
      .addr_zero(addr_zero),
      .ras_n    (dram_ras_n),
      .cas_n    (dram_cas_n),
      .we_n     (dram_we_n),
      .dq_oe    (dram_dq_oe),
      .dq_in    (dram_dq_in),
      .done     (done),
      .rd_data  (rd_data)
   );

   dram_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W), .MUX_W(MUX_W)) u_mux (
      .row    (open_row),
      .col    (req_addr[COL_W-1:0]),
      .sel_row(sel_row),
      .zero   (addr_zero),
      .pins   (dram_addr)
   );

   assign dram_dq_out = req_wdata;

   // column strobe low with row strobe high only happens in refresh: pins parked
   assert_refresh_addr_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!dram_cas_n && dram_ras_n) |-> (dram_addr == '0 && dram_we_n && !dram_dq_oe));

endmodule

// File: tb/tb_dram_ctl.sv
`timescale 1ns/1ps
module tb_dram_ctl;
   localparam int RW = 4, CW = 4, DW = 8;
   localparam int AW = RW + CW;
   localparam int P_ASR = 1, P_RCD = 2, P_CAS = 2, P_CP = 2, P_RP = 3, P_CSR = 2;
   localparam int P_KHZ = 16, P_RET = 64;
   localparam int REF_EXP = (P_KHZ * P_RET) / (2 ** RW);   // 64 cycles

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_we = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          done;
   logic [DW-1:0] rd_data;
   logic [RW-1:0] dram_addr;
   logic          dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
   logic [DW-1:0] dram_dq_out, dram_dq_in;

   always #2.5 clk = ~clk;

   dram_ctl #(
      .ROW_W(RW), .COL_W(CW), .DATA_W(DW), .CLK_KHZ(P_KHZ), .RETAIN_MS(P_RET),
      .T_ASR(P_ASR), .T_RCD(P_RCD), .T_CAS(P_CAS), .T_CP(P_CP), .T_RP(P_RP), .T_CSR(P_CSR)
   ) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
      .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .rd_data(rd_data),
      .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
      .dram_we_n(dram_we_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
      .dram_dq_in(dram_dq_in)
   );

   int checks = 0, errors = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] pat(input logic [RW-1:0] r, input logic [CW-1:0] c);
      return {r, c} ^ 8'h5C;
   endfunction

   // ---------------- behavioural device and pin monitor ----------------
   logic [DW-1:0] mem [2**AW];
   logic [RW-1:0] row_l = '0;
   logic [CW-1:0] col_l = '0;
   logic prev_ras = 1'b1, prev_cas = 1'b1, ref_cas = 1'b0;
   int cyc = 0;
   int ras_fall_c = -1000, ras_rise_c = -1000, cas_fall_c = -1000, cas_rise_c = -1000;
   int ref_cnt = 0, ref_prev_c = 0, ref_last_c = 0, opens = 0;
   bit in_burst = 1'b0;
   int open_base = 0, brk = 0;

   initial for (int i = 0; i < 2**AW; i++) mem[i] = '0;

   assign dram_dq_in = mem[{row_l, dram_addr[CW-1:0]}];

   always @(negedge clk) begin
      if (rst_n) begin
         cyc++;
         if (prev_cas && !dram_cas_n) begin
            cas_fall_c = cyc;
            if (dram_ras_n) begin
               ref_cas = 1'b1;
               ref_cnt++;
               ref_prev_c = ref_last_c;
               ref_last_c = cyc;
               if (in_burst && opens > open_base) brk++;
               chk(dram_addr == '0 && dram_we_n && !dram_dq_oe, "R9 refresh pins at CAS fall",
                   dram_addr, 0);
            end else begin
               ref_cas = 1'b0;
               col_l = dram_addr[CW-1:0];
               if (cas_rise_c < ras_fall_c)
                  chk(cyc - ras_fall_c == P_RCD, "R3 RAS-to-CAS", cyc - ras_fall_c, P_RCD);
               else
                  chk(cyc - cas_rise_c == P_CP, "R6 CAS gap in page", cyc - cas_rise_c, P_CP);
               if (!dram_we_n) begin
                  chk(dram_dq_oe, "R4 write drives data", dram_dq_oe, 1);
                  mem[{row_l, col_l}] = dram_dq_out;
               end else begin
                  chk(!dram_dq_oe, "R4 read leaves data undriven", dram_dq_oe, 0);
               end
            end
         end
         if (prev_ras && !dram_ras_n) begin
            chk(cyc - ras_rise_c >= P_RP, "R7 RAS precharge", cyc - ras_rise_c, P_RP);
            if (!dram_cas_n) begin
               chk(cyc - cas_fall_c == P_CSR, "R8 CAS-before-RAS lead", cyc - cas_fall_c, P_CSR);
               chk(dram_addr == '0 && dram_we_n, "R9 refresh pins at RAS fall", dram_addr, 0);
            end else begin
               ras_fall_c = cyc;
               row_l = dram_addr[RW-1:0];
               opens++;
            end
         end
         if (!prev_cas && dram_cas_n) begin
            cas_rise_c = cyc;
            if (ref_cas)
               chk(cyc - cas_fall_c == P_CSR + P_CAS, "R8 refresh CAS width",
                   cyc - cas_fall_c, P_CSR + P_CAS);
            else
               chk(cyc - cas_fall_c == P_CAS, "R3 CAS width", cyc - cas_fall_c, P_CAS);
         end
         if (!prev_ras && dram_ras_n) begin
            ras_rise_c = cyc;
            chk(dram_cas_n, "R7 CAS high at RAS rise", dram_cas_n, 1);
         end
         prev_ras = dram_ras_n;
         prev_cas = dram_cas_n;
         if (cyc > 150000) begin
            chk(1'b0, "watchdog", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
         end
      end
   end

   // ---------------- scenario tasks ----------------
   task automatic wait_done();
      int t = 0;
      do begin
         @(negedge clk);
         t++;
      end while (!done && t < 2000);
      if (!done) chk(1'b0, "watchdog waiting for done", t, 2000);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(dram_ras_n && dram_cas_n && dram_we_n, "R1 strobes idle in reset",
          {dram_ras_n, dram_cas_n, dram_we_n}, 7);
      chk(!done && !dram_dq_oe && dram_addr == '0, "R1 outputs quiet in reset",
          {done, dram_dq_oe, dram_addr}, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(dram_ras_n && dram_cas_n && !done && dram_addr == '0, "R1 idle after reset",
          {dram_ras_n, dram_cas_n, done}, 6);
   endtask

   task automatic t_access(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input logic [DW-1:0] exp_rd);
      @(negedge clk);
      req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
      wait_done();
      req_valid = 1'b0;
      chk(row_l == a[AW-1:CW], "R2 row on pins", row_l, a[AW-1:CW]);
      chk(col_l == a[CW-1:0], "R2 column on pins", col_l, a[CW-1:0]);
      if (!we) chk(rd_data == exp_rd, "R5 read data", rd_data, exp_rd);
      @(negedge clk);
      chk(!done, "R5 done lasts one cycle", done, 0);
      @(negedge clk);
      chk(dram_ras_n, "R7 row closes with no request", dram_ras_n, 1);
   endtask

   task automatic t_burst(input bit we, input logic [RW-1:0] r, input int n, input string tag);
      @(negedge clk);
      in_burst = 1'b1; open_base = opens; brk = 0;
      req_valid = 1'b1; req_we = we;
      for (int i = 0; i < n; i++) begin
         req_addr  = {r, CW'(i)};
         req_wdata = pat(r, CW'(i));
         wait_done();
         if (!we) chk(rd_data == pat(r, CW'(i)), {tag, " burst data"}, rd_data, pat(r, CW'(i)));
      end
      req_valid = 1'b0;
      in_burst = 1'b0;
      chk(opens - open_base == 1 + brk, {tag, " row opened once per page segment"},
          opens - open_base, 1 + brk);
      repeat (8) @(negedge clk);
   endtask

   task automatic t_two_rows();
      @(negedge clk);
      in_burst = 1'b1; open_base = opens; brk = 0;
      req_valid = 1'b1; req_we = 1'b0; req_addr = {4'd3, 4'd2};
      wait_done();
      chk(rd_data == pat(4'd3, 4'd2), "R7 first row data", rd_data, pat(4'd3, 4'd2));
      req_addr = {4'd6, 4'd9};
      wait_done();
      req_valid = 1'b0; in_burst = 1'b0;
      chk(rd_data == pat(4'd6, 4'd9), "R7 second row data", rd_data, pat(4'd6, 4'd9));
      chk(opens - open_base == 2 + brk, "R7 row change reopens", opens - open_base, 2 + brk);
      repeat (8) @(negedge clk);
   endtask

   task automatic t_idle_refresh();
      int base = ref_cnt;
      int t = 0;
      req_valid = 1'b0;
      while (ref_cnt < base + 3 && t < 1000) begin
         @(negedge clk);
         t++;
      end
      chk(ref_cnt >= base + 3, "R8 refreshes occur while idle", ref_cnt - base, 3);
      chk(ref_last_c - ref_prev_c == REF_EXP, "R8 refresh interval",
          ref_last_c - ref_prev_c, REF_EXP);
   endtask

   task automatic t_long_burst();
      int b;
      t_burst(1'b0, 4'd9, 48, "R10");
      b = brk;
      chk(b >= 1, "R10 refresh broke into the page burst", b, 1);
   endtask

   initial begin
      t_reset();
      t_access(1'b1, 8'h5A, 8'hC3, 8'h00);                 // R4 write
      t_access(1'b0, 8'h5A, 8'h00, 8'hC3);                 // R5 read back
      t_access(1'b1, 8'hA5, 8'h3C, 8'h00);
      t_access(1'b0, 8'hA5, 8'h00, 8'h3C);
      t_access(1'b0, 8'h5A, 8'h00, 8'hC3);
      t_burst(1'b1, 4'd3, 16, "R6 write");                 // page writes
      t_burst(1'b1, 4'd6, 16, "R6 write");
      t_burst(1'b1, 4'd9, 16, "R6 write");
      t_burst(1'b0, 4'd3, 6, "R6 read");                   // page reads
      t_two_rows();
      t_idle_refresh();
      t_long_burst();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule